// File: doc/BRIEF.md
# 4B/5B Transmit Symbol Encoder

This block sits at the transmit side of a nibble-wide link. It takes one 4-bit nibble per cycle of the 25 MHz nibble clock, together with a transmit-enable and an error flag. Each cycle it produces one registered 5-bit code group. While no frame is in progress it keeps the line filled with the IDLE code. When a frame opens, the first two enabled nibble slots are overwritten by the start-delimiter pair J, K. Later nibbles are translated through the fixed 16-entry data table. The cycle in which enable drops, and the cycle after it, carry the end-delimiter pair T, R. An error flag raised in a data slot replaces that slot's code with HALT.

A small framing state machine chooses which class of code goes out in each slot: idle, a delimiter, data or halt. A separate mapping stage turns that choice, and the nibble, into the 5-bit pattern. A single output register gives a fixed latency of one cycle. Scrambling, serialisation, line coding and the receive direction belong to other blocks.

Top module: `sym_tx_encoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `code_o` is IDLE = 5'b11111.
- R2: While no frame is in progress and `tx_en` is low, `code_o` is IDLE (11111) in every cycle.
- R3: A slot in which `tx_en` is high while the encoder is idle opens a frame. That slot is output as J = 5'b11000. The next slot is output as K = 5'b10001, whatever `tx_en`, `tx_err` and `tx_nib` hold in it.
- R4: Each data slot (`tx_en` high, after K, `tx_err` low) outputs the code of `tx_nib`. The table is 0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101.
- R5: The first slot after the data in which `tx_en` is low outputs T = 5'b01101. The next slot outputs R = 5'b00111. After that the encoder is idle again.
- R6: A data slot with `tx_err` high outputs HALT = 5'b00100 instead of the data code. The frame continues, and later data slots are encoded normally.
- R7: `tx_err` has no effect in the J and K slots, in the T and R slots, or while idle.
- R8: If `tx_en` is already low in the K slot, K is still sent, and the T, R pair follows in the next two slots.
- R9: `tx_en` high during the T or R slot of an end delimiter is ignored. The delimiter completes. A new frame opens with J at the first idle slot in which `tx_en` is high.
- R10: The code for a slot appears on `code_o` exactly one clock edge after that slot's inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable for the current slot |
| tx_err | input | 1 | Fault flag for the current slot |
| tx_nib | input | 4 | Data nibble for the current slot |
| code_o | output | 5 | Registered 5-bit code group |

## Verification
Two pairs of functions can meet in one slot. The first is the error flag and delimiter insertion: `tx_err` is raised in the K slot and in the T slot, and the result must still be the delimiter, never HALT. The second is the end delimiter and a new frame start: `tx_en` is raised again in the T or R slot, and the delimiter must complete before J appears. The scoreboard records the expected code for every driven slot from the requirement tables, so any substitution or any shift of one slot shows up at the output compare.

// File: rtl/sym_enc_pkg.sv
package sym_enc_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t C_IDLE = 5'b11111;
  localparam code_t C_J    = 5'b11000;
  localparam code_t C_K    = 5'b10001;
  localparam code_t C_T    = 5'b01101;
  localparam code_t C_R    = 5'b00111;
  localparam code_t C_HALT = 5'b00100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K, ST_DATA, ST_T, ST_R
  } frm_st_e;

  typedef enum logic [2:0] {
    SEL_IDLE, SEL_J, SEL_K, SEL_DATA, SEL_HALT, SEL_T, SEL_R
  } sel_e;

  function automatic code_t data_code(nib_t n);
    code_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sym_tx_frame_fsm.sv
module sym_tx_frame_fsm
  import sym_enc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tx_en,
  input  logic    tx_err,
  output sel_e    sel_o,
  output frm_st_e st_o
);
  frm_st_e st_q, st_d;
  sel_e    sel;

  always_comb begin
    sel  = SEL_IDLE;
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (tx_en) begin
        sel  = SEL_J;
        st_d = ST_K;
      end
      ST_K: begin
        sel  = SEL_K;
        st_d = tx_en ? ST_DATA : ST_T;
      end
      ST_DATA: if (tx_en) begin
        sel = tx_err ? SEL_HALT : SEL_DATA;
      end else begin
        sel  = SEL_T;
        st_d = ST_R;
      end
      ST_T: begin
        sel  = SEL_T;
        st_d = ST_R;
      end
      ST_R: begin
        sel  = SEL_R;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign sel_o = sel;
  assign st_o  = st_q;

  // Named events for the checks
  logic ev_start, ev_late_fall, ev_halt;
  assign ev_start     = (st_q == ST_IDLE) && tx_en;
  assign ev_late_fall = (st_q == ST_K) && !tx_en;
  assign ev_halt      = (st_q == ST_DATA) && tx_en && tx_err;

  // R3
  start_to_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> st_q == ST_K);
  // R8
  late_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_late_fall |=> st_q == ST_T);
  // R5
  t_to_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_T |=> st_q == ST_R);
  // R9
  r_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_R |=> st_q == ST_IDLE);
  // R6
  halt_keeps_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt |=> st_q == ST_DATA);
endmodule

// File: rtl/sym_tx_code_map.sv
module sym_tx_code_map
  import sym_enc_pkg::*;
(
  input  sel_e  sel_i,
  input  nib_t  nib_i,
  output code_t code_o
);
  always_comb begin
    case (sel_i)
      SEL_J:    code_o = C_J;
      SEL_K:    code_o = C_K;
      SEL_DATA: code_o = data_code(nib_i);
      SEL_HALT: code_o = C_HALT;
      SEL_T:    code_o = C_T;
      SEL_R:    code_o = C_R;
      default:  code_o = C_IDLE;
    endcase
  end
endmodule

// File: rtl/sym_tx_encoder.sv
module sym_tx_encoder
  import sym_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_err,
  input  logic [NIB_W-1:0] tx_nib,
  output logic [CODE_W-1:0] code_o
);
  sel_e    sel;
  frm_st_e st;
  code_t   code_d;

  sym_tx_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_err(tx_err),
    .sel_o(sel), .st_o(st)
  );

  sym_tx_code_map u_map (
    .sel_i(sel), .nib_i(tx_nib), .code_o(code_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_o <= C_IDLE;
    else        code_o <= code_d;
  end

  logic ev_quiet, ev_data;
  assign ev_quiet = (st == ST_IDLE) && !tx_en;
  assign ev_data  = (st == ST_DATA) && tx_en && !tx_err;

  // R2
  idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_quiet |=> code_o == C_IDLE);
  // R3
  j_then_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_o == C_J |=> code_o == C_K);
  // R5
  t_then_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_o == C_T |=> code_o == C_R);
  // R4
  data_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> code_o == data_code($past(tx_nib)));
  // R6
  halt_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DATA) && tx_en && tx_err) |=> code_o == C_HALT);
endmodule

// File: tb/sym_tx_encoder_tb_top.sv
module sym_tx_encoder_tb_top;
  localparam int CLK_PERIOD = 40;
  // Data codes F down to 0, five bits each
  localparam logic [79:0] TBL = {
    5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
    5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110};
  localparam logic [4:0] E_I = 5'b11111, E_J = 5'b11000, E_K = 5'b10001,
                         E_T = 5'b01101, E_R = 5'b00111, E_H = 5'b00100;

  logic clk = 0, rst_n = 0, tx_en = 0, tx_err = 0;
  logic [3:0] tx_nib = 0;
  logic [4:0] code_o;
  int n_run = 0, n_fail = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];

  sym_tx_encoder dut_i (.clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .tx_err(tx_err), .tx_nib(tx_nib), .code_o(code_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] dcode(input logic [3:0] n);
    return TBL[n*5 +: 5];
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic slot(input logic en, input logic err, input logic [3:0] nib,
                      input logic [4:0] exp, input string tag);
    @(negedge clk);
    tx_en = en; tx_err = err; tx_nib = nib;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: each slot's code appears after the following posedge (R10)
  initial forever begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, code_o, e);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tx_en = 1; tx_err = 1; tx_nib = 4'h3;
    repeat (3) @(negedge clk);
    check("R1 in reset", code_o, E_I);
    tx_en = 0; tx_err = 0;
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", code_o, E_I);

    // R2 idle fill, error ignored while idle (R7)
    slot(0, 0, 4'h5, E_I, "R2 idle");
    slot(0, 1, 4'hA, E_I, "R7 err while idle");
    slot(0, 0, 4'h0, E_I, "R2 idle");

    // Full frame through the whole data table
    slot(1, 0, 4'h5, E_J, "R3 J slot");
    slot(1, 1, 4'h9, E_K, "R7 err in K slot");
    for (int i = 0; i < 16; i++) slot(1, 0, 4'(i), dcode(4'(i)), "R4 data table");
    slot(0, 1, 4'h2, E_T, "R5 T with err R7");
    slot(0, 1, 4'h2, E_R, "R5 R with err R7");
    slot(0, 0, 4'h2, E_I, "R5 back to idle");

    // Error inside the data
    slot(1, 1, 4'h1, E_J, "R7 err in J slot");
    slot(1, 0, 4'h1, E_K, "R3 K");
    slot(1, 0, 4'h3, dcode(4'h3), "R4 data before halt");
    slot(1, 1, 4'h7, E_H, "R6 halt");
    slot(1, 0, 4'hA, dcode(4'hA), "R6 data after halt");
    slot(0, 0, 4'h0, E_T, "R5 T");
    slot(0, 0, 4'h0, E_R, "R5 R");
    slot(0, 0, 4'h0, E_I, "R2 idle");

    // Enable drops in the K slot, raised again during T and R
    slot(1, 0, 4'h4, E_J, "R8 J");
    slot(0, 0, 4'h4, E_K, "R8 K still sent");
    slot(1, 0, 4'h4, E_T, "R9 T despite enable");
    slot(1, 0, 4'h4, E_R, "R9 R despite enable");
    slot(1, 0, 4'h6, E_J, "R9 new frame J");
    slot(1, 0, 4'h6, E_K, "R9 K");
    slot(1, 0, 4'hC, dcode(4'hC), "R4 data");
    slot(0, 0, 4'h0, E_T, "R5 T");
    slot(1, 1, 4'h0, E_R, "R9 R with enable");
    slot(0, 0, 4'h0, E_I, "R9 idle when enable low");
    slot(0, 0, 4'h0, E_I, "R2 idle");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule